// File: doc/BRIEF.md
# Status Flag Register and Branch Decision Unit

This block keeps the eight-bit processor status word and works out the next program counter for conditional branches and skips. Each cycle it receives an instruction class together with its operands. From these it applies flag writes to the status word and reports whether control flow changes, what the next program counter is, and how many cycles the instruction takes.

Flag writes take three forms. The ALU can merge new flags under a per-bit mask. A single status bit can be set or cleared. The T bit can also be loaded from a bit of a general register. In the other direction, a bit-load operation returns a general register value with one bit replaced by T.

Branch tests can check any single status bit for set or clear, or the signed comparison result formed from N and V. Skips can test register equality or a single register bit. A skip jumps over a one-word or a two-word following instruction.

The decision outputs are combinational and depend on the status word as it stands in the current cycle. Flag writes become visible on the next clock edge.

Top module: `flag_branch_unit`

## Requirements
- R1: A synchronous active-high reset clears the status word to 0x00. Status bits from 7 down to 0 are I, T, H, S, V, N, Z, C.
- R2: Class 1 (ALU update) loads `alu_flags` into every status bit whose `alu_mask` bit is 1 and keeps the other bits. The new value is visible after the next clock edge.
- R3: Class 2 sets status bit `bit_sel` to 1 and class 3 clears it to 0. No other status bit changes.
- R4: Class 4 (bit store) copies `reg_val[bit_sel]` into T (bit 6) and leaves the other status bits unchanged.
- R5: For class 5 (bit load), `reg_out` equals `reg_val` with bit `bit_sel` replaced by the current T, in the same cycle. For every other class, `reg_out` equals `reg_val`.
- R6: Class 6 is taken when status bit `bit_sel` is 1, and class 7 is taken when it is 0. A taken branch gives `next_pc = pc + offset + 1` and `cycles = 2`.
- R7: Class 8 (signed greater-or-equal) is taken when N XOR V is 0, and class 9 (signed less-than) is taken when N XOR V is 1. The stored S bit does not affect either decision.
- R8: When no branch or skip is taken, or the class is not a branch or skip, `taken = 0`, `next_pc = pc + 1` and `cycles = 1`.
- R9: Class 10 skips when `reg_val == cmp_val`. Class 11 skips when `reg_val[bit_sel]` is 1, and class 12 skips when it is 0. A skip gives `pc + 2` with 2 cycles when `next_two_word` is 0, and `pc + 3` with 3 cycles when it is 1.
- R10: `offset` is a signed two's-complement value. All program-counter arithmetic wraps modulo 2^PC_W.
- R11: Class 0 and classes 5 to 12 leave the status word unchanged, whatever values `alu_flags` and `alu_mask` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_class | input | 4 | Instruction class code (see requirements) |
| bit_sel | input | 3 | Status-bit or register-bit index |
| alu_flags | input | 8 | Flag values from the ALU |
| alu_mask | input | 8 | Flags the ALU is updating |
| reg_val | input | 8 | General register operand |
| cmp_val | input | 8 | Second register operand for skip-if-equal |
| pc | input | PC_W | Current program counter |
| offset | input | OFF_W | Signed relative branch offset |
| next_two_word | input | 1 | Following instruction is two words long |
| sreg | output | 8 | Current status word |
| reg_out | output | 8 | Register value after bit load |
| taken | output | 1 | Branch or skip taken |
| next_pc | output | PC_W | Next program counter |
| cycles | output | 2 | Cycles used by the instruction |

## Verification
Branches are driven against status words built up by masked ALU merges, single-bit writes and T transfers. This exposes a branch that tests the wrong bit or inverts its sense.

The signed tests run with N and V disagreeing while S is held at zero, and again with N and V agreeing. This separates a decision taken from N XOR V from one that reads the stored S bit. Offsets are positive, negative and wrapping around zero, which catches sign-extension and carry mistakes.

Skips run for both instruction lengths and for both outcomes. Classes that must not write the status word run with live flag and mask inputs, and are each followed by a readback of the status word.

// File: rtl/fbu_pkg.sv
package fbu_pkg;

    localparam int unsigned SR_W  = 8;
    localparam int unsigned IDX_W = $clog2(SR_W);

    // status bit positions
    localparam int unsigned SR_I = 7;
    localparam int unsigned SR_T = 6;
    localparam int unsigned SR_H = 5;
    localparam int unsigned SR_S = 4;
    localparam int unsigned SR_V = 3;
    localparam int unsigned SR_N = 2;
    localparam int unsigned SR_Z = 1;
    localparam int unsigned SR_C = 0;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_ALU    = 4'd1,
        OP_BSET   = 4'd2,
        OP_BCLR   = 4'd3,
        OP_TSTORE = 4'd4,
        OP_TLOAD  = 4'd5,
        OP_BRS    = 4'd6,
        OP_BRC    = 4'd7,
        OP_BRGE   = 4'd8,
        OP_BRLT   = 4'd9,
        OP_SKEQ   = 4'd10,
        OP_SKBS   = 4'd11,
        OP_SKBC   = 4'd12
    } op_e;

    typedef struct packed {
        logic is_br;
        logic is_sk;
        logic hit;
    } cond_t;

    function automatic logic is_branch(op_e op);
        return (op == OP_BRS) || (op == OP_BRC) || (op == OP_BRGE) || (op == OP_BRLT);
    endfunction

    function automatic logic is_skip(op_e op);
        return (op == OP_SKEQ) || (op == OP_SKBS) || (op == OP_SKBC);
    endfunction

    function automatic logic writes_sreg(op_e op);
        return (op == OP_ALU) || (op == OP_BSET) || (op == OP_BCLR) || (op == OP_TSTORE);
    endfunction

endpackage

// File: rtl/fbu_status_reg.sv
module fbu_status_reg
    import fbu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  op_e              op,
    input  logic [IDX_W-1:0] bit_sel,
    input  logic [SR_W-1:0]  alu_flags,
    input  logic [SR_W-1:0]  alu_mask,
    input  logic [SR_W-1:0]  reg_val,
    output logic [SR_W-1:0]  sreg_q,
    output logic [SR_W-1:0]  reg_out
);

    logic [SR_W-1:0] sreg_d;

    always_comb begin
        sreg_d = sreg_q;
        case (op)
            OP_ALU:    sreg_d = (sreg_q & ~alu_mask) | (alu_flags & alu_mask);
            OP_BSET:   sreg_d[bit_sel] = 1'b1;
            OP_BCLR:   sreg_d[bit_sel] = 1'b0;
            OP_TSTORE: sreg_d[SR_T] = reg_val[bit_sel];
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) sreg_q <= '0;
        else     sreg_q <= sreg_d;
    end

    always_comb begin
        reg_out = reg_val;
        if (op == OP_TLOAD) reg_out[bit_sel] = sreg_q[SR_T];
    end

    // R1: status word reads zero in the first cycle out of reset
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (sreg_q == '0));

    // R3
    p_set_bit_r3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BSET) |=> sreg_q[$past(bit_sel)]);

    p_clr_bit_r3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BCLR) |=> !sreg_q[$past(bit_sel)]);

    // R4
    p_store_t_r4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_TSTORE) |=> (sreg_q[SR_T] == $past(reg_val[bit_sel])));

    // R11
    p_keep_r11: assert property (@(posedge clk) disable iff (rst)
        !writes_sreg(op) |=> $stable(sreg_q));

endmodule

// File: rtl/fbu_cond_eval.sv
module fbu_cond_eval
    import fbu_pkg::*;
(
    input  op_e              op,
    input  logic [SR_W-1:0]  sreg,
    input  logic [IDX_W-1:0] bit_sel,
    input  logic [SR_W-1:0]  reg_val,
    input  logic [SR_W-1:0]  cmp_val,
    output cond_t            cond
);

    logic signed_lt;

    assign signed_lt = sreg[SR_N] ^ sreg[SR_V];

    always_comb begin
        cond.is_br = is_branch(op);
        cond.is_sk = is_skip(op);
        case (op)
            OP_BRS:  cond.hit = sreg[bit_sel];
            OP_BRC:  cond.hit = !sreg[bit_sel];
            OP_BRGE: cond.hit = !signed_lt;
            OP_BRLT: cond.hit = signed_lt;
            OP_SKEQ: cond.hit = (reg_val == cmp_val);
            OP_SKBS: cond.hit = reg_val[bit_sel];
            OP_SKBC: cond.hit = !reg_val[bit_sel];
            default: cond.hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/fbu_pc_calc.sv
module fbu_pc_calc
    import fbu_pkg::*;
#(
    parameter int unsigned PC_W  = 12,
    parameter int unsigned OFF_W = 7
) (
    input  logic [PC_W-1:0]         pc,
    input  logic signed [OFF_W-1:0] offset,
    input  cond_t                   cond,
    input  logic                    two_word,
    output logic                    taken,
    output logic [PC_W-1:0]         next_pc,
    output logic [1:0]              cycles
);

    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] skip_step;

    assign off_ext   = PC_W'(offset);
    assign skip_step = two_word ? PC_W'(3) : PC_W'(2);

    always_comb begin
        taken   = cond.hit && (cond.is_br || cond.is_sk);
        next_pc = pc + PC_W'(1);
        cycles  = 2'd1;
        if (cond.is_br && cond.hit) begin
            next_pc = pc + off_ext + PC_W'(1);
            cycles  = 2'd2;
        end else if (cond.is_sk && cond.hit) begin
            next_pc = pc + skip_step;
            cycles  = two_word ? 2'd3 : 2'd2;
        end
    end

endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit
    import fbu_pkg::*;
#(
    parameter int unsigned PC_W  = 12,
    parameter int unsigned OFF_W = 7
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [3:0]              op_class,
    input  logic [2:0]              bit_sel,
    input  logic [7:0]              alu_flags,
    input  logic [7:0]              alu_mask,
    input  logic [7:0]              reg_val,
    input  logic [7:0]              cmp_val,
    input  logic [PC_W-1:0]         pc,
    input  logic signed [OFF_W-1:0] offset,
    input  logic                    next_two_word,
    output logic [7:0]              sreg,
    output logic [7:0]              reg_out,
    output logic                    taken,
    output logic [PC_W-1:0]         next_pc,
    output logic [1:0]              cycles
);

    op_e   op;
    cond_t cond;

    assign op = op_e'(op_class);

    fbu_status_reg u_sreg (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .bit_sel   (bit_sel),
        .alu_flags (alu_flags),
        .alu_mask  (alu_mask),
        .reg_val   (reg_val),
        .sreg_q    (sreg),
        .reg_out   (reg_out)
    );

    fbu_cond_eval u_cond (
        .op      (op),
        .sreg    (sreg),
        .bit_sel (bit_sel),
        .reg_val (reg_val),
        .cmp_val (cmp_val),
        .cond    (cond)
    );

    fbu_pc_calc #(.PC_W(PC_W), .OFF_W(OFF_W)) u_pc (
        .pc       (pc),
        .offset   (offset),
        .cond     (cond),
        .two_word (next_two_word),
        .taken    (taken),
        .next_pc  (next_pc),
        .cycles   (cycles)
    );

    // R8
    p_not_taken_r8: assert property (@(posedge clk) disable iff (rst)
        !taken |-> ((next_pc == pc + PC_W'(1)) && (cycles == 2'd1)));

    // R6
    p_branch_cycles_r6: assert property (@(posedge clk) disable iff (rst)
        (taken && is_branch(op)) |-> (cycles == 2'd2));

    // R9
    p_skip_cycles_r9: assert property (@(posedge clk) disable iff (rst)
        (taken && is_skip(op)) |-> (cycles == (next_two_word ? 2'd3 : 2'd2)));

    // R5
    p_reg_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (op != OP_TLOAD) |-> (reg_out == reg_val));

endmodule

// File: tb/flag_branch_unit_bench.sv
module flag_branch_unit_bench;

    localparam int PC_W  = 12;
    localparam int OFF_W = 7;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [3:0]              op_class = '0;
    logic [2:0]              bit_sel = '0;
    logic [7:0]              alu_flags = '0;
    logic [7:0]              alu_mask = '0;
    logic [7:0]              reg_val = '0;
    logic [7:0]              cmp_val = '0;
    logic [PC_W-1:0]         pc = '0;
    logic signed [OFF_W-1:0] offset = '0;
    logic                    next_two_word = 1'b0;
    logic [7:0]              sreg;
    logic [7:0]              reg_out;
    logic                    taken;
    logic [PC_W-1:0]         next_pc;
    logic [1:0]              cycles;

    always #10 clk = ~clk;

    flag_branch_unit #(.PC_W(PC_W), .OFF_W(OFF_W)) u_flag_branch_unit (
        .clk(clk), .rst(rst), .op_class(op_class), .bit_sel(bit_sel),
        .alu_flags(alu_flags), .alu_mask(alu_mask), .reg_val(reg_val),
        .cmp_val(cmp_val), .pc(pc), .offset(offset),
        .next_two_word(next_two_word), .sreg(sreg), .reg_out(reg_out),
        .taken(taken), .next_pc(next_pc), .cycles(cycles)
    );

    typedef struct {
        string           tag;
        logic            chk_sreg;
        logic [7:0]      sreg;
        logic [7:0]      reg_out;
        logic            taken;
        logic [PC_W-1:0] next_pc;
        logic [1:0]      cycles;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    logic [7:0] sreg_m = '0;
    logic       sreg_known = 1'b0;
    bit         done = 1'b0;

    task automatic apply(input string tag, input logic r, input logic [3:0] op,
                         input logic [2:0] bs, input logic [7:0] fl,
                         input logic [7:0] mk, input logic [7:0] rv,
                         input logic [7:0] cv, input logic [PC_W-1:0] p,
                         input logic signed [OFF_W-1:0] off, input logic tw);
        exp_t e;
        logic hit;
        logic [PC_W-1:0] off_x;
        @(negedge clk);
        rst = r; op_class = op; bit_sel = bs; alu_flags = fl; alu_mask = mk;
        reg_val = rv; cmp_val = cv; pc = p; offset = off; next_two_word = tw;
        off_x = {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
        e.tag = tag; e.chk_sreg = sreg_known; e.sreg = sreg_m;
        e.reg_out = rv;
        if (op == 4'd5) e.reg_out[bs] = sreg_m[6];
        case (op)
            4'd6:  hit = sreg_m[bs];
            4'd7:  hit = !sreg_m[bs];
            4'd8:  hit = (sreg_m[2] == sreg_m[3]);
            4'd9:  hit = (sreg_m[2] != sreg_m[3]);
            4'd10: hit = (rv == cv);
            4'd11: hit = rv[bs];
            4'd12: hit = !rv[bs];
            default: hit = 1'b0;
        endcase
        e.taken = hit; e.next_pc = p + 1; e.cycles = 2'd1;
        if (hit && op >= 4'd6 && op <= 4'd9) begin
            e.next_pc = p + off_x + 1; e.cycles = 2'd2;
        end else if (hit) begin
            e.next_pc = p + (tw ? 3 : 2); e.cycles = tw ? 2'd3 : 2'd2;
        end
        exp_q.push_back(e);
        if (r) begin
            sreg_m = '0; sreg_known = 1'b1;
        end else begin
            case (op)
                4'd1: sreg_m = (sreg_m & ~mk) | (fl & mk);
                4'd2: sreg_m[bs] = 1'b1;
                4'd3: sreg_m[bs] = 1'b0;
                4'd4: sreg_m[6] = rv[bs];
                default: ;
            endcase
        end
    endtask

    task automatic cmp(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // monitor: pops one expected item per driven cycle
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.chk_sreg) cmp(e.tag, "sreg", 32'(sreg), 32'(e.sreg));
                cmp(e.tag, "reg_out", 32'(reg_out), 32'(e.reg_out));
                cmp(e.tag, "taken", 32'(taken), 32'(e.taken));
                cmp(e.tag, "next_pc", 32'(next_pc), 32'(e.next_pc));
                cmp(e.tag, "cycles", 32'(cycles), 32'(e.cycles));
            end
        end
    end

    initial begin
        #(64'd4_000_000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        apply("R1", 1, 0, 0, 8'hFF, 8'hFF, 0, 0, 12'h010, 0, 0);
        apply("R1", 0, 0, 0, 0, 0, 0, 0, 12'h010, 0, 0);
        // R2 masked ALU merges
        apply("R2", 0, 1, 0, 8'hA5, 8'hFF, 0, 0, 12'h020, 0, 0);
        apply("R2", 0, 1, 0, 8'h00, 8'h0F, 0, 0, 12'h021, 0, 0);
        // R3 single-bit writes
        apply("R3", 0, 2, 0, 8'h00, 8'hFF, 0, 0, 12'h022, 0, 0);
        apply("R3", 0, 3, 7, 8'hFF, 8'hFF, 0, 0, 12'h023, 0, 0);
        // R4 bit store
        apply("R4", 0, 4, 3, 0, 0, 8'h08, 0, 12'h024, 0, 0);
        apply("R4", 0, 4, 3, 0, 0, 8'hF7, 0, 12'h025, 0, 0);
        apply("R4", 0, 4, 0, 0, 0, 8'h01, 0, 12'h026, 0, 0);
        // R5 bit load
        apply("R5", 0, 5, 5, 8'hFF, 8'hFF, 8'h00, 0, 12'h027, 0, 0);
        apply("R5", 0, 5, 2, 0, 0, 8'hFB, 0, 12'h028, 0, 0);
        apply("R5", 0, 0, 2, 0, 0, 8'h5A, 0, 12'h029, 0, 0);
        // R6 any-bit branches
        apply("R6", 0, 6, 0, 0, 0, 0, 0, 12'h100, 7'sd5, 0);
        apply("R8", 0, 7, 0, 0, 0, 0, 0, 12'h100, 7'sd5, 0);
        apply("R6", 0, 6, 6, 8'hFF, 8'hFF, 0, 0, 12'h100, -7'sd3, 0);
        apply("R8", 0, 6, 7, 0, 0, 0, 0, 12'h100, 7'sd9, 0);
        apply("R6", 0, 7, 7, 0, 0, 0, 0, 12'h200, 7'sd12, 0);
        // R7 signed tests: N=1 V=0 S=0
        apply("R2", 0, 1, 0, 8'h04, 8'h1C, 0, 0, 12'h300, 0, 0);
        apply("R7", 0, 8, 0, 0, 0, 0, 0, 12'h300, 7'sd4, 0);
        apply("R7", 0, 9, 0, 0, 0, 0, 0, 12'h300, 7'sd4, 0);
        apply("R3", 0, 2, 3, 0, 0, 0, 0, 12'h301, 0, 0);
        apply("R7", 0, 8, 0, 0, 0, 0, 0, 12'h310, -7'sd16, 0);
        apply("R7", 0, 9, 0, 0, 0, 0, 0, 12'h310, -7'sd16, 0);
        // R10 wrap
        apply("R10", 0, 6, 0, 0, 0, 0, 0, 12'hFFF, 7'sd0, 0);
        apply("R10", 0, 6, 0, 0, 0, 0, 0, 12'h002, -7'sd64, 0);
        apply("R10", 0, 12, 1, 0, 0, 8'h00, 0, 12'hFFE, 0, 1);
        // R9 skips
        apply("R9", 0, 10, 0, 0, 0, 8'h05, 8'h05, 12'h010, 0, 0);
        apply("R9", 0, 10, 0, 0, 0, 8'h05, 8'h05, 12'h010, 0, 1);
        apply("R9", 0, 10, 0, 0, 0, 8'h05, 8'h06, 12'h010, 0, 1);
        apply("R9", 0, 11, 7, 0, 0, 8'h80, 0, 12'h040, 0, 1);
        apply("R9", 0, 12, 7, 0, 0, 8'h80, 0, 12'h040, 0, 1);
        apply("R9", 0, 12, 4, 0, 0, 8'h00, 0, 12'h050, 0, 0);
        // R11 non-writing classes with live flag inputs
        apply("R11", 0, 0, 1, 8'hFF, 8'hFF, 8'hFF, 0, 12'h060, 0, 0);
        apply("R11", 0, 9, 1, 8'h00, 8'hFF, 8'hFF, 0, 12'h061, 0, 0);
        apply("R11", 0, 13, 1, 8'hFF, 8'hFF, 8'hFF, 0, 12'h062, 0, 0);
        apply("R11", 0, 0, 0, 0, 0, 0, 0, 12'h063, 0, 0);
        // R1 reset mid-run
        apply("R1", 1, 1, 0, 8'hFF, 8'hFF, 0, 0, 12'h070, 0, 0);
        apply("R1", 0, 0, 0, 0, 0, 0, 0, 12'h071, 0, 0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule